// File: doc/BRIEF.md
# Burst Memory Bus Responder

This block sits on the memory side of a cache refill path and answers read requests with words taken from an internal register file. It models a slow external bus: the first word of any transfer costs a fixed number of wait states, and every following word of the same burst arrives one bus cycle after the previous one. A burst therefore spends 3 + (N-1) bus cycles from the request to the final word, so longer bursts cost fewer bus cycles per word.

The bus cycle is not the core clock. An internal divider produces a one-core-cycle enable every `DIV` core clocks, and all responder state moves only on that enable. The request side is a valid/ready handshake: the requester holds `req_valid` with a stable address and length code until it sees `req_ready` high in the same core cycle, and the transfer is taken at that clock edge. `req_ready` is high only on a bus-cycle enable while no burst is in progress, so any request made during a burst waits. The response side has no back-pressure: each word is presented with a single-core-cycle `rsp_valid` strobe, and the consumer must take it in that cycle.

Top module: `burst_responder`

## Requirements
- R1: While no burst is in progress, `req_ready` is high for exactly one core cycle in every `DIV` core cycles, and it is never high while a burst is in progress.
- R2: The 2-bit `req_len` code selects the burst size: 00 gives 1 word, 01 gives 2, 10 gives 4, 11 gives 8; exactly that many `rsp_valid` strobes follow an accepted request.
- R3: Word k of a burst (k = 0 first) is read from word address `req_addr + k`, wrapping modulo 2^`ADDR_W`.
- R4: With the default of 2 wait states, the first word is strobed 2*`DIV` core cycles after the accepting clock edge, i.e. in the third bus cycle counting the request cycle.
- R5: Each later word is strobed exactly `DIV` core cycles after the previous one, so the final word of an N-word burst comes (N+1)*`DIV` core cycles after acceptance, a total of 3 + (N-1) bus cycles.
- R6: `rsp_valid` is high for one core cycle per word and at no other time; `rsp_last` is high only together with the strobe of the final word.
- R7: A request presented while a burst is in progress is not accepted and changes neither the data, the count nor the timing of that burst.
- R8: The word stored at address a holds {8'hC3, a, ~a, a ^ 8'h5A} (each field 8 bits, taken from the low 8 address bits).
- R9: After reset release, `rsp_valid` and `rsp_last` stay low, and `req_ready` first rises in the (`DIV`-1)-th core cycle after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken at this edge when valid is also high |
| req_addr | input | ADDR_W | Start word address |
| req_len | input | 2 | Burst size code |
| rsp_valid | output | 1 | One-core-cycle word strobe |
| rsp_data | output | 32 | Returned word, meaningful with rsp_valid |
| rsp_last | output | 1 | Marks the final word of a burst |

## Verification
The hardest case to reach is a request that arrives while a burst is still streaming, because from the ports it looks like a normal handshake attempt and only its absence of effect shows anything. The stimulus holds `req_valid` high with a different address and length code throughout chosen bursts, then checks that `req_ready` stays low until the final word, that the returned words still follow the original start address, and that the word count and timing match the original code. Random bursts with directed ones at address wrap and at every length cover the per-length latency of 3 + (N-1) bus cycles.

// File: rtl/burst_pkg.sv
package burst_pkg;

  localparam int WORD_W    = 32;
  localparam int MAX_BURST = 8;
  localparam int LEFT_W    = $clog2(MAX_BURST + 1);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DATA = 2'd2
  } seq_state_e;

  // Size code to word count: 1 shifted by the code.
  function automatic logic [LEFT_W-1:0] code_to_words(input logic [1:0] code);
    logic [LEFT_W-1:0] one;
    one = LEFT_W'(1);
    return one << code;
  endfunction

  // Fixed contents of each storage entry.
  function automatic logic [WORD_W-1:0] fill_word(input logic [7:0] a);
    return {8'hC3, a, ~a, a ^ 8'h5A};
  endfunction

endpackage

// File: rtl/bus_tick_gen.sv
module bus_tick_gen #(
  parameter int DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);

  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;

  generate
    if (DIV > 1) begin : g_div
      always_ff @(posedge clk) begin
        if (!rst_n)                     cnt_q <= '0;
        else if (cnt_q == CW'(DIV - 1)) cnt_q <= '0;
        else                            cnt_q <= cnt_q + CW'(1);
      end
      assign tick = (cnt_q == CW'(DIV - 1));

      // R1: the enable never appears in two neighbouring core cycles
      p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end else begin : g_nodiv
      always_ff @(posedge clk) cnt_q <= '0;
      assign tick = rst_n & ~cnt_q[0];
    end
  endgenerate

endmodule

// File: rtl/burst_store.sv
module burst_store
  import burst_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
      always_ff @(posedge clk) begin
        if (!rst_n) mem[i] <= fill_word(8'(i));
      end
    end
  endgenerate

  assign rd_data = mem[rd_addr];

  // R8: the top byte of every entry carries the fixed marker once loaded
  p_marker_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (rd_data[WORD_W-1 -: 8] == 8'hC3));

endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int WAIT_ST = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_len,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rsp_valid,
  output logic              rsp_last
);

  localparam int WW = (WAIT_ST > 1) ? $clog2(WAIT_ST + 1) : 1;

  seq_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEFT_W-1:0] left_q;
  logic [WW-1:0]     wcnt_q;
  logic              take;

  assign req_ready = (state_q == ST_IDLE) && tick;
  assign take      = req_ready && req_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      left_q  <= '0;
      wcnt_q  <= '0;
    end else if (tick) begin
      unique case (state_q)
        ST_IDLE: begin
          if (take) begin
            addr_q  <= req_addr;
            left_q  <= code_to_words(req_len);
            wcnt_q  <= '0;
            state_q <= (WAIT_ST > 1) ? ST_WAIT : ST_DATA;
          end
        end
        ST_WAIT: begin
          if (int'(wcnt_q) >= WAIT_ST - 2) state_q <= ST_DATA;
          else                             wcnt_q  <= wcnt_q + WW'(1);
        end
        ST_DATA: begin
          if (left_q == LEFT_W'(1)) begin
            state_q <= ST_IDLE;
            left_q  <= '0;
          end else begin
            addr_q <= addr_q + ADDR_W'(1);
            left_q <= left_q - LEFT_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_addr   = addr_q;
  assign rsp_valid = (state_q == ST_DATA) && tick;
  assign rsp_last  = rsp_valid && (left_q == LEFT_W'(1));

  // R1 / R7: no handshake offered once a burst is under way
  p_ready_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |-> !req_ready);

  // R6: word strobes coincide with the bus-cycle enable from the divider
  p_valid_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> tick);

  // R5: after the final word the sequencer is idle again
  p_last_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_last) |=> (state_q == ST_IDLE));

  // R5: state moves only on the bus-cycle enable
  p_state_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(state_q));

  // R2: the word count is untouched while wait states run
  p_wait_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT) |=> $stable(left_q));

endmodule

// File: rtl/burst_responder.sv
module burst_responder
  import burst_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DIV     = 10,
  parameter int WAIT_ST = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_len,
  output logic              rsp_valid,
  output logic [31:0]       rsp_data,
  output logic              rsp_last
);

  logic              tick;
  logic [ADDR_W-1:0] rd_addr;
  logic [WORD_W-1:0] rd_data;

  bus_tick_gen #(.DIV(DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  burst_seq #(.ADDR_W(ADDR_W), .WAIT_ST(WAIT_ST)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_len   (req_len),
    .rd_addr   (rd_addr),
    .rsp_valid (rsp_valid),
    .rsp_last  (rsp_last)
  );

  burst_store #(.ADDR_W(ADDR_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  assign rsp_data = rd_data;

  // R6: a final-word mark never appears without its strobe
  p_last_with_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_last |-> rsp_valid);

endmodule

// File: tb/tb_burst_responder.sv
`timescale 1ns/1ps
module tb_burst_responder;

  localparam int ADDR_W = 8;
  localparam int DIV    = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [1:0]        req_len = '0;
  logic              rsp_valid;
  logic [31:0]       rsp_data;
  logic              rsp_last;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  burst_responder #(.ADDR_W(ADDR_W), .DIV(DIV), .WAIT_ST(2)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_len   (req_len),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rsp_last  (rsp_last)
  );

  function automatic logic [31:0] exp_word(input logic [7:0] a);
    return {8'hC3, a, ~a, a ^ 8'h5A};
  endfunction

  function automatic int words_of(input logic [1:0] code);
    case (code)
      2'b00:   return 1;
      2'b01:   return 2;
      2'b10:   return 4;
      default: return 8;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic run_burst(input logic [ADDR_W-1:0] addr, input logic [1:0] len,
                           input bit intrude);
    int n;
    int got;
    int stray;
    int ready_bad;
    int first_m;
    int last_m;
    n = words_of(len);
    got = 0; stray = 0; ready_bad = 0; first_m = -1; last_m = -1;
    @(negedge clk);
    req_valid = 1'b1; req_addr = addr; req_len = len;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    if (intrude) begin
      req_addr = addr + 8'd37;
      req_len  = ~len;
    end else begin
      req_valid = 1'b0;
    end
    for (int m = 1; m <= (n + 2) * DIV; m++) begin
      if (m > 1) @(negedge clk);
      if (m == (n + 1) * DIV + 1) req_valid = 1'b0;
      if (m < (n + 2) * DIV && req_ready) ready_bad++;
      if ((m % DIV) == 0 && (m / DIV) >= 2 && (m / DIV) <= n + 1) begin
        int k;
        k = m / DIV - 2;
        chk(rsp_valid, "R5", "strobe at word slot", rsp_valid, 1);
        if (rsp_valid) begin
          got++;
          if (first_m < 0) first_m = m;
          last_m = m;
          chk(rsp_data == exp_word(addr + 8'(k)), "R3/R8", "word data",
              rsp_data, exp_word(addr + 8'(k)));
          chk(rsp_last == (k == n - 1), "R6", "last flag", rsp_last, (k == n - 1));
        end
      end else if (rsp_valid || rsp_last) begin
        stray++;
      end
      if (m == (n + 2) * DIV)
        chk(req_ready, "R1", "ready back after burst", req_ready, 1);
    end
    chk(got == n, "R2", "word count", got, n);
    chk(first_m == 2 * DIV, "R4", "first word delay", first_m, 2 * DIV);
    chk(last_m == (n + 1) * DIV, "R5", "last word delay", last_m, (n + 1) * DIV);
    chk(stray == 0, "R6", "stray strobes", stray, 0);
    chk(ready_bad == 0, intrude ? "R7" : "R1", "ready while busy", ready_bad, 0);
  endtask

  initial begin
    #800000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int first_rdy;
    int rdy_cnt;
    int bad_out;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    first_rdy = -1; rdy_cnt = 0; bad_out = 0;
    for (int m = 1; m <= 3 * DIV; m++) begin
      @(negedge clk);
      if (req_ready) begin
        rdy_cnt++;
        if (first_rdy < 0) first_rdy = m;
      end
      if (rsp_valid || rsp_last) bad_out++;
    end
    chk(bad_out == 0, "R9", "outputs quiet after reset", bad_out, 0);
    chk(first_rdy == DIV - 1, "R9", "first ready cycle", first_rdy, DIV - 1);
    chk(rdy_cnt == 3, "R1", "idle ready pulses", rdy_cnt, 3);

    // Directed: each size code, wrap at top address, busy intrusion.
    run_burst(8'h00, 2'b00, 1'b0);
    run_burst(8'h10, 2'b01, 1'b0);
    run_burst(8'h20, 2'b10, 1'b0);
    run_burst(8'hFC, 2'b11, 1'b0);
    run_burst(8'hFF, 2'b10, 1'b0);
    run_burst(8'h40, 2'b11, 1'b1);
    run_burst(8'h77, 2'b00, 1'b1);
    run_burst(8'hFE, 2'b01, 1'b1);

    // Random mix.
    for (int i = 0; i < 40; i++) begin
      logic [7:0] a;
      logic [1:0] l;
      a = 8'($urandom());
      l = 2'($urandom());
      run_burst(a, l, ($urandom() % 4) == 0);
    end

    summary();
    $finish;
  end

endmodule